// File: doc/BRIEF.md
# Countdown Event Timer with Split Count Registers

This block is a 32-bit down-counter used to time events chosen by software. Software loads the count through two 16-bit read/write registers, one for each half. A write-one command register starts and stops the timer. While the timer runs, each pulse on a single-cycle tick-enable input lowers the count by one. That input stands in for the transmit-clock rate that paces the count.

When the count passes from all zeros to all ones, a sticky wrap flag is set and counting goes on from the top. The interrupt output is raised while that flag and an enable bit are both set. Reset halts the timer but leaves the count as it is, so software can inspect it afterwards. The register port is a plain synchronous write port with a combinational read path.

Register map (3-bit address): 0 = count bits 15:0, 1 = count bits 31:16, 2 = command (write bit 0 starts, write bit 1 stops, reads 0), 3 = status (bit 0 running, read-only; bit 1 wrap flag, write 1 to clear), 4 = interrupt enable (bit 0). Other addresses read 0.

Top module: `evtmr_top`

## Requirements
- R1: Writing address 0 or 1 loads count bits 15:0 or 31:16, and reading either address returns the live bits of that half.
- R2: While running, the count falls by exactly one on each clock cycle with `tickEn` high. While halted, `tickEn` leaves the count unchanged.
- R3: A decrement from 0000_0000h gives FFFF_FFFFh and sets the wrap flag. `irq` is high exactly when the wrap flag and interrupt-enable bit 0 (address 4) are both 1.
- R4: After a wrap the timer keeps running and goes on decrementing from FFFF_FFFFh.
- R5: Writing 1 to command bit 0 (address 2) starts the timer and writing 1 to command bit 1 halts it. Status bit 0 (address 3) reads 1 exactly while the timer runs.
- R6: If both command bits are written as 1 in the same write, the timer is halted afterwards.
- R7: The wrap flag (status bit 1) is set whether or not the interrupt is enabled, stays set, and is cleared by writing 1 to status bit 1.
- R8: With `rst_n` low, the timer is halted at the next edge and no decrement happens in that cycle. The count value is kept.
- R9: A write to one half takes effect at the next edge and has priority over a decrement in the same cycle. The other half is not changed in that cycle.
- R10: At power-up the count is 0, the wrap flag and enable bit are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; halts the timer only |
| tickEn | input | 1 | One-cycle pulse per count tick |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt, wrap flag AND enable |

## Verification
The hardest cases to reach from the ports are the cycles where two causes meet. One is a tick that coincides with a half-register write. The other is a tick that coincides with reset while the timer runs. The bench drives `tickEn` in the same cycle as the write strobe, or as the reset low pulse, and then reads both halves back to confirm that neither a decrement nor a change to the other half slipped through. The wrap is reached by loading a small count so that only a few ticks cross zero. The flag is checked with the interrupt still disabled, and the enable is set only afterwards.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int REG_W     = 16;
  localparam int NUM_PARTS = 2;
  localparam int CNT_W     = REG_W * NUM_PARTS;
  localparam int ADDR_W    = 3;
  localparam int ADDR_CMD  = NUM_PARTS;
  localparam int ADDR_STAT = NUM_PARTS + 1;
  localparam int ADDR_MASK = NUM_PARTS + 2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PARTS-1:0] load;
    logic                 dec;
  } dpCtl_t;
endpackage

// File: rtl/evtmr_ctl.sv
module evtmr_ctl
  import evtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cmdBits,
  input  logic              wrapEvt,
  output dpCtl_t            dpCtl,
  output logic              running,
  output logic              wrapFlag,
  output logic              maskBit
);
  logic runQ  = 1'b0;
  logic flagQ = 1'b0;
  logic maskQ = 1'b0;
  logic [NUM_PARTS-1:0] loadVec;

  for (genvar g = 0; g < NUM_PARTS; g++) begin : gLoad
    assign loadVec[g] = wrEn && (addr == ADDR_W'(g));
  end

  logic cmdWr, startStb, stopStb, statWr, maskWr;
  assign cmdWr    = wrEn && (addr == ADDR_W'(ADDR_CMD));
  assign startStb = cmdWr && cmdBits[0];
  assign stopStb  = cmdWr && cmdBits[1];
  assign statWr   = wrEn && (addr == ADDR_W'(ADDR_STAT));
  assign maskWr   = wrEn && (addr == ADDR_W'(ADDR_MASK));

  always_comb begin
    dpCtl.load = loadVec;
    dpCtl.dec  = runQ && tickEn && rst_n && !(|loadVec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        runQ <= 1'b0;
    else if (stopStb)  runQ <= 1'b0;
    else if (startStb) runQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrapEvt)                   flagQ <= 1'b1;
    else if (statWr && cmdBits[1]) flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (maskWr) maskQ <= cmdBits[0];
  end

  assign running  = runQ;
  assign wrapFlag = flagQ;
  assign maskBit  = maskQ;
endmodule

// File: rtl/evtmr_dp.sv
module evtmr_dp
  import evtmr_pkg::*;
(
  input  logic             clk,
  input  dpCtl_t           dpCtl,
  input  logic [REG_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             wrapEvt
);
  logic [CNT_W-1:0] decVal;
  assign decVal = cnt - CNT_W'(1);

  for (genvar g = 0; g < NUM_PARTS; g++) begin : gPart
    logic [REG_W-1:0] partQ = '0;
    always_ff @(posedge clk) begin
      if (dpCtl.load[g])  partQ <= wrData;
      else if (dpCtl.dec) partQ <= decVal[g*REG_W +: REG_W];
    end
    assign cnt[g*REG_W +: REG_W] = partQ;
  end

  assign wrapEvt = dpCtl.dec && (cnt == '0);
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              irq
);
  dpCtl_t           dpCtl;
  logic [CNT_W-1:0] cnt;
  logic             wrapEvt, running, wrapFlag, maskBit;

  evtmr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .cmdBits(wrData[1:0]), .wrapEvt(wrapEvt), .dpCtl(dpCtl),
    .running(running), .wrapFlag(wrapFlag), .maskBit(maskBit)
  );

  evtmr_dp u_dp (
    .clk(clk), .dpCtl(dpCtl), .wrData(wrData), .cnt(cnt), .wrapEvt(wrapEvt)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_PARTS; i++) begin
      if (addr == ADDR_W'(i)) rdData = cnt[i*REG_W +: REG_W];
    end
    if (addr == ADDR_W'(ADDR_STAT)) rdData = {{(REG_W-2){1'b0}}, wrapFlag, running};
    if (addr == ADDR_W'(ADDR_MASK)) rdData = {{(REG_W-1){1'b0}}, maskBit};
  end

  assign irq = wrapFlag && maskBit;
endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk
  import evtmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wrData,
  input logic [CNT_W-1:0]  cnt,
  input logic              running,
  input logic              wrapFlag
);
  logic cntWr;
  assign cntWr = wrEn && (addr < ADDR_W'(NUM_PARTS));

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && tickEn && !cntWr |=> cnt == $past(cnt) - CNT_W'(1));

  // R2
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cntWr |=> $stable(cnt));

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && tickEn && !cntWr && cnt == '0 |=> wrapFlag && cnt == '1);

  // R6
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && addr == ADDR_W'(ADDR_CMD) && wrData[1] |=> !running);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && addr == ADDR_W'(ADDR_STAT) && wrData[1] && !(running && tickEn)
    |=> !wrapFlag);

  // R8
  reset_halt_chk: assert property (@(posedge clk)
    !rst_n |=> !running);

  // R8
  reset_keep_chk: assert property (@(posedge clk)
    !rst_n && !wrEn |=> $stable(cnt));

  // R9
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && addr == ADDR_W'(0) |=> cnt[REG_W-1:0] == $past(wrData) && cnt[CNT_W-1:REG_W] == $past(cnt[CNT_W-1:REG_W]));
endmodule

bind evtmr_top evtmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .cnt(cnt), .running(running), .wrapFlag(wrapFlag)
);

// File: tb/evtmr_top_tb.sv
module evtmr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    string       tag;
    bit          isIrq;
    logic [15:0] exp;
  } item_t;
  item_t q[$];
  event sampleEv;

  always #2.5 clk = ~clk;

  evtmr_top u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // monitor: pop expected items and compare with the outputs
  initial forever begin
    @(sampleEv);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = it.isIrq ? {15'b0, irq} : rdData;
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expRd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wrEn = 1'b0;
    addr = a;
    #1;
    it.tag = tag; it.isIrq = 1'b0; it.exp = e;
    q.push_back(it);
    ->sampleEv;
  endtask

  task automatic expIrq(input bit e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.tag = tag; it.isIrq = 1'b1; it.exp = {15'b0, e};
    q.push_back(it);
    ->sampleEv;
  endtask

  task automatic expCnt(input logic [31:0] e, input string tag);
    expRd(3'd0, e[15:0], tag);
    expRd(3'd1, e[31:16], tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 power-up state
    expCnt(32'h0, "R10 count at power-up");
    expIrq(1'b0, "R10 irq at power-up");
    rst_n = 1'b1;
    expRd(3'd3, 16'h0000, "R5 status idle after reset");

    // R1 load and read back both halves
    wr(3'd0, 16'h0005);
    wr(3'd1, 16'h0000);
    expCnt(32'h0000_0005, "R1 half registers load");
    wr(3'd1, 16'hA5C3);
    expRd(3'd1, 16'hA5C3, "R1 upper half readback");
    wr(3'd1, 16'h0000);

    // R2 ticks ignored while halted
    tick(3);
    expCnt(32'h0000_0005, "R2 halted ignores ticks");

    // R5 start, R2 decrement
    wr(3'd2, 16'h0001);
    expRd(3'd3, 16'h0001, "R5 running bit after start");
    expRd(3'd2, 16'h0000, "R5 command reads zero");
    tick(3);
    expCnt(32'h0000_0002, "R2 decrement by ticks");

    // R3 wrap with interrupt disabled, R7 flag set anyway
    tick(3);
    expCnt(32'hFFFF_FFFF, "R3 wrap to all ones");
    expRd(3'd3, 16'h0003, "R7 flag set while masked");
    expIrq(1'b0, "R3 irq masked");
    wr(3'd4, 16'h0001);
    expRd(3'd4, 16'h0001, "R3 enable bit readback");
    expIrq(1'b1, "R3 irq after enable");

    // R4 continues after wrap
    tick(2);
    expCnt(32'hFFFF_FFFD, "R4 keeps counting after wrap");
    expRd(3'd3, 16'h0003, "R7 flag sticky");

    // R7 write-one clear
    wr(3'd3, 16'h0002);
    expRd(3'd3, 16'h0001, "R7 flag cleared");
    expIrq(1'b0, "R7 irq drops after clear");

    // R5 stop
    wr(3'd2, 16'h0002);
    expRd(3'd3, 16'h0000, "R5 halted after stop");
    tick(4);
    expCnt(32'hFFFF_FFFD, "R5 no count after stop");

    // R6 start and stop together
    wr(3'd2, 16'h0003);
    expRd(3'd3, 16'h0000, "R6 stop has priority");
    tick(2);
    expCnt(32'hFFFF_FFFD, "R6 still halted");

    // R8 reset halts, keeps count, blocks a tick in the same cycle
    wr(3'd2, 16'h0001);
    tick(1);
    expCnt(32'hFFFF_FFFC, "R8 running before reset");
    @(negedge clk);
    rst_n = 1'b0; tickEn = 1'b1;
    @(negedge clk);
    rst_n = 1'b1; tickEn = 1'b0;
    expRd(3'd3, 16'h0000, "R8 reset halts timer");
    expCnt(32'hFFFF_FFFC, "R8 reset keeps count");
    tick(2);
    expCnt(32'hFFFF_FFFC, "R8 stays halted after reset");

    // R9 half write beats a decrement in the same cycle
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0010);
    wr(3'd2, 16'h0001);
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; addr = 3'd0; wrData = 16'h1234;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    expCnt(32'h0000_1234, "R9 low write wins over tick");
    tick(1);
    expCnt(32'h0000_1233, "R9 counting resumes");
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; addr = 3'd1; wrData = 16'h0002;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    expCnt(32'h0002_1233, "R9 high write keeps low half");

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule